// File: doc/BRIEF.md
# Smart Card Transmit Status Flags

This block holds the two transmit-side status flags of an ISO 7816 style smart card serial port. The error flag records that the receiving card pulled the I/O line low during the guard period to report a parity error. The transmit-end flag tells software or DMA that the port has no more work. It rises a guard-mode-dependent delay after a character finishes, provided no further data is waiting and no error was reported. Framing errors play no part in this mode, so no framing flag exists.

The block does not contain the shifter, the baud generator or the parity logic. It takes strobes from them: a half-etu tick (two pulses per elementary time unit), a character-done pulse, and a sample strobe with the sampled error-signal level. It also takes the CPU's read and write strobes for the two software-clearable flags, a data-register write strobe from the CPU or DMA, and a low-power request that covers both standby and module stop. Both flags use a read-then-write-zero clear. A set condition in the same cycle as a clear wins over the clear.

Top module: `sc_tx_status`

## Requirements
- R1: During reset the error flag is 0 and the transmit-end flag is 1. Both are taken synchronously.
- R2: When the sample strobe is high, the sampled level is 0 and transmit enable is 1, the error flag is 1 after that clock edge. A sampled level of 1 leaves the flag unchanged.
- R3: The error flag clears only on a write of 0 that follows an error-flag read which returned 1. A write of 0 with no such earlier read leaves the flag at 1. A clear disarms the sequence.
- R4: When a set condition and a software or data-write clear occur in the same cycle, the flag is set. This applies to both flags.
- R5: Dropping transmit enable leaves the error flag at its previous value.
- R6: While transmit enable is 0 and the error flag is 0, the transmit-end flag is 1 from the next cycle. While the error flag is 1, a low transmit enable does not force it.
- R7: With guard mode 0, the transmit-end flag rises at the 5th half-etu tick after the character-done pulse (2.5 etu), and not before.
- R8: With guard mode 1, the transmit-end flag rises at the 2nd half-etu tick after the character-done pulse (1.0 etu), and not before.
- R9: The delayed set happens only if data-register-empty is 1 and the error flag is 0 at the expiry tick.
- R10: The transmit-end flag clears on a data-register write strobe. It also clears on an empty-flag write of 0 that follows an empty-flag read made while data-register-empty was 1. Without that read, the write of 0 has no effect.
- R11: A low-power request makes the error flag 0 and the transmit-end flag 1 after the next edge, and it cancels any pending delay.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pwr_down_i | input | 1 | Standby or module-stop request |
| half_etu_tick_i | input | 1 | One-cycle pulse, twice per etu |
| char_done_i | input | 1 | Character has left the shifter |
| err_sample_i | input | 1 | Strobe: error-signal level is valid |
| err_level_i | input | 1 | Sampled line level (0 = error reported) |
| tx_en_i | input | 1 | Transmit enable |
| guard_mode_i | input | 1 | 0 = 2.5 etu end delay, 1 = 1.0 etu |
| tdr_empty_i | input | 1 | Data-register-empty status |
| err_rd_i | input | 1 | CPU read of the error flag |
| err_wr_i | input | 1 | CPU write of the error flag |
| err_wr_data_i | input | 1 | Value written to the error flag |
| empty_rd_i | input | 1 | CPU read of the data-empty flag |
| empty_wr_i | input | 1 | CPU write of the data-empty flag |
| empty_wr_data_i | input | 1 | Value written to the data-empty flag |
| data_wr_i | input | 1 | Data register written (CPU or DMA) |
| err_flag_o | output | 1 | Error-signal flag |
| tx_end_o | output | 1 | Transmit-end flag |

## Verification
The delay is swept over both guard modes, crossed with data-register-empty and the error flag. After every tick the bench compares the flag with the tick index against the mode's threshold, so an off-by-one delay or a swapped mode shows up as an early or late rise. Clears are tried as armed and unarmed writes of 0, and again in the same cycle as a set, to tell a wrong arming rule from a wrong priority. Transmit enable and low power are toggled with the error flag both 0 and 1, which separates the idle forcing of the transmit-end flag from the retention of the error flag.

// File: rtl/sc_txs_pkg.sv
// Shared constants for the smart card transmit status block.
// Assumes the etu tick arrives twice per elementary time unit.
package sc_txs_pkg;
    // Half-etu ticks from end of character to transmit-end, per guard mode.
    localparam int unsigned GM0_HALF_TICKS = 5;
    localparam int unsigned GM1_HALF_TICKS = 2;

    // Guard mode encoding.
    typedef enum logic {
        GUARD_LONG  = 1'b0,
        GUARD_SHORT = 1'b1
    } guard_mode_e;
endpackage

// File: rtl/sc_txs_rw0_arm.sv
// Read-one-then-write-zero clear sequencer.
// Arms when a read happens while the watched flag is 1. An armed write of 0
// produces a one-cycle clear request and disarms. A flush also disarms.
module sc_txs_rw0_arm (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic rd_i,
    input  logic flag_i,
    input  logic wr_i,
    input  logic wr_data_i,
    output logic clr_o
);
    logic armed_q;

    // Clear request: armed and software writes a zero.
    always_comb clr_o = armed_q && wr_i && !wr_data_i;

    // Arming state: set by a read that returns 1, dropped by any clear.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            armed_q <= 1'b0;
        end else if (clr_o) begin
            armed_q <= 1'b0;
        end else if (rd_i && flag_i) begin
            armed_q <= 1'b1;
        end
    end
endmodule

// File: rtl/sc_txs_guard_timer.sv
// Counts half-etu ticks after a character and pulses expire_o on the tick
// that completes the guard-mode delay. A new character restarts it.
// Assumes char_done and a tick never need to count in the same cycle.
module sc_txs_guard_timer
    import sc_txs_pkg::*;
#(
    parameter int unsigned LONG_TICKS  = GM0_HALF_TICKS,
    parameter int unsigned SHORT_TICKS = GM1_HALF_TICKS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic flush_i,
    input  logic start_i,
    input  logic tick_i,
    input  logic guard_mode_i,
    output logic expire_o
);
    localparam int unsigned MAX_TICKS = (LONG_TICKS > SHORT_TICKS) ? LONG_TICKS : SHORT_TICKS;
    localparam int unsigned CNT_W     = $clog2(MAX_TICKS + 1);
    localparam logic [CNT_W-1:0] LONG_TGT  = CNT_W'(LONG_TICKS);
    localparam logic [CNT_W-1:0] SHORT_TGT = CNT_W'(SHORT_TICKS);

    logic             busy_q;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tgt_q;
    logic [CNT_W-1:0] cnt_inc;

    // Next tick count and expiry on the tick that reaches the target.
    always_comb begin
        cnt_inc  = cnt_q + CNT_W'(1);
        expire_o = busy_q && tick_i && !start_i && (cnt_inc == tgt_q);
    end

    // Delay state: load target on start, count ticks, stop on expiry.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
            tgt_q  <= '0;
        end else if (start_i) begin
            busy_q <= 1'b1;
            cnt_q  <= '0;
            tgt_q  <= (guard_mode_e'(guard_mode_i) == GUARD_SHORT) ? SHORT_TGT : LONG_TGT;
        end else if (expire_o) begin
            busy_q <= 1'b0;
            cnt_q  <= '0;
        end else if (busy_q && tick_i) begin
            cnt_q  <= cnt_inc;
        end
    end
endmodule

// File: rtl/sc_txs_err_flag.sv
// Error-signal flag. Set when the returned line is sampled low during
// transmission. Cleared by low power or an armed write of zero. Set wins.
module sc_txs_err_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down_i,
    input  logic sample_i,
    input  logic level_i,
    input  logic tx_en_i,
    input  logic sw_clr_i,
    output logic flag_o
);
    logic set_c;

    // Set condition: a low sample while the transmitter is enabled.
    always_comb set_c = sample_i && !level_i && tx_en_i;

    // Flag register with low power first, then set over software clear.
    always_ff @(posedge clk) begin
        if (!rst_n || pwr_down_i) begin
            flag_o <= 1'b0;
        end else if (set_c) begin
            flag_o <= 1'b1;
        end else if (sw_clr_i) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/sc_txs_end_flag.sv
// Transmit-end flag. Set by low power, by idle with no error, or by the
// guard-delay expiry when data is empty and no error. Cleared by a data
// write or an armed empty-flag clear. Set wins.
module sc_txs_end_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down_i,
    input  logic tx_en_i,
    input  logic err_i,
    input  logic expire_i,
    input  logic tdr_empty_i,
    input  logic data_wr_i,
    input  logic sw_clr_i,
    output logic flag_o
);
    logic set_c;
    logic clr_c;

    // Set and clear conditions.
    always_comb begin
        set_c = pwr_down_i
              || (!tx_en_i && !err_i)
              || (expire_i && tdr_empty_i && !err_i);
        clr_c = data_wr_i || sw_clr_i;
    end

    // Flag register, reset value 1, set over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b1;
        end else if (set_c) begin
            flag_o <= 1'b1;
        end else if (clr_c) begin
            flag_o <= 1'b0;
        end
    end
endmodule

// File: rtl/sc_tx_status.sv
// Top of the smart card transmit status block: wires the two clear
// sequencers, the guard-delay timer and the two flag registers.
// Assumes all strobes are one clock wide and synchronous to clk.
module sc_tx_status
    import sc_txs_pkg::*;
#(
    parameter int unsigned LONG_TICKS  = GM0_HALF_TICKS,
    parameter int unsigned SHORT_TICKS = GM1_HALF_TICKS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pwr_down_i,
    input  logic half_etu_tick_i,
    input  logic char_done_i,
    input  logic err_sample_i,
    input  logic err_level_i,
    input  logic tx_en_i,
    input  logic guard_mode_i,
    input  logic tdr_empty_i,
    input  logic err_rd_i,
    input  logic err_wr_i,
    input  logic err_wr_data_i,
    input  logic empty_rd_i,
    input  logic empty_wr_i,
    input  logic empty_wr_data_i,
    input  logic data_wr_i,
    output logic err_flag_o,
    output logic tx_end_o
);
    logic err_sw_clr;
    logic empty_sw_clr;
    logic expire;
    logic err_q;

    sc_txs_rw0_arm u_err_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (pwr_down_i),
        .rd_i      (err_rd_i),
        .flag_i    (err_q),
        .wr_i      (err_wr_i),
        .wr_data_i (err_wr_data_i),
        .clr_o     (err_sw_clr)
    );

    sc_txs_rw0_arm u_empty_arm (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (pwr_down_i),
        .rd_i      (empty_rd_i),
        .flag_i    (tdr_empty_i),
        .wr_i      (empty_wr_i),
        .wr_data_i (empty_wr_data_i),
        .clr_o     (empty_sw_clr)
    );

    sc_txs_guard_timer #(
        .LONG_TICKS  (LONG_TICKS),
        .SHORT_TICKS (SHORT_TICKS)
    ) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .flush_i      (pwr_down_i),
        .start_i      (char_done_i),
        .tick_i       (half_etu_tick_i),
        .guard_mode_i (guard_mode_i),
        .expire_o     (expire)
    );

    sc_txs_err_flag u_err (
        .clk        (clk),
        .rst_n      (rst_n),
        .pwr_down_i (pwr_down_i),
        .sample_i   (err_sample_i),
        .level_i    (err_level_i),
        .tx_en_i    (tx_en_i),
        .sw_clr_i   (err_sw_clr),
        .flag_o     (err_q)
    );

    sc_txs_end_flag u_end (
        .clk         (clk),
        .rst_n       (rst_n),
        .pwr_down_i  (pwr_down_i),
        .tx_en_i     (tx_en_i),
        .err_i       (err_q),
        .expire_i    (expire),
        .tdr_empty_i (tdr_empty_i),
        .data_wr_i   (data_wr_i),
        .sw_clr_i    (empty_sw_clr),
        .flag_o      (tx_end_o)
    );

    // Output of the error flag.
    always_comb err_flag_o = err_q;
endmodule

// File: rtl/sc_tx_status_chk.sv
// Property checker for sc_tx_status, attached by bind below.
module sc_tx_status_chk (
    input logic clk,
    input logic rst_n,
    input logic pwr_down_i,
    input logic err_sample_i,
    input logic err_level_i,
    input logic tx_en_i,
    input logic tdr_empty_i,
    input logic err_wr_i,
    input logic err_wr_data_i,
    input logic empty_wr_i,
    input logic empty_wr_data_i,
    input logic data_wr_i,
    input logic err_flag_o,
    input logic tx_end_o
);
    assert_err_rise_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(err_flag_o) |-> $past(err_sample_i && !err_level_i && tx_en_i));

    assert_err_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(err_flag_o) |-> $past(pwr_down_i || (err_wr_i && !err_wr_data_i)));

    assert_err_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (err_sample_i && !err_level_i && tx_en_i && !pwr_down_i) |=> err_flag_o);

    assert_idle_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_en_i && !err_flag_o) |=> tx_end_o);

    assert_end_rise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_end_o) |-> $past(pwr_down_i || !err_flag_o));

    assert_end_fall_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(tx_end_o) |-> $past(data_wr_i || (empty_wr_i && !empty_wr_data_i)));

    assert_low_power_R11: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down_i |=> (!err_flag_o && tx_end_o));

    assert_empty_dep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(tx_end_o) && $past(tx_en_i) && !$past(pwr_down_i)) |-> $past(tdr_empty_i));
endmodule

bind sc_tx_status sc_tx_status_chk u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .pwr_down_i      (pwr_down_i),
    .err_sample_i    (err_sample_i),
    .err_level_i     (err_level_i),
    .tx_en_i         (tx_en_i),
    .tdr_empty_i     (tdr_empty_i),
    .err_wr_i        (err_wr_i),
    .err_wr_data_i   (err_wr_data_i),
    .empty_wr_i      (empty_wr_i),
    .empty_wr_data_i (empty_wr_data_i),
    .data_wr_i       (data_wr_i),
    .err_flag_o      (err_flag_o),
    .tx_end_o        (tx_end_o)
);

// File: tb/tb_sc_tx_status.sv
module tb_sc_tx_status;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic pwr_down_i = 0, half_etu_tick_i = 0, char_done_i = 0;
    logic err_sample_i = 0, err_level_i = 1, tx_en_i = 0, guard_mode_i = 0;
    logic tdr_empty_i = 0, err_rd_i = 0, err_wr_i = 0, err_wr_data_i = 0;
    logic empty_rd_i = 0, empty_wr_i = 0, empty_wr_data_i = 0, data_wr_i = 0;
    logic err_flag_o, tx_end_o;
    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #10 clk = ~clk;

    sc_tx_status dut (.*);

    task automatic check(input logic act, input logic exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // One cycle: inputs set before this call take effect at the coming edge.
    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic clear_strobes();
        half_etu_tick_i = 0; char_done_i = 0; err_sample_i = 0; err_level_i = 1;
        err_rd_i = 0; err_wr_i = 0; err_wr_data_i = 0;
        empty_rd_i = 0; empty_wr_i = 0; empty_wr_data_i = 0; data_wr_i = 0;
        pwr_down_i = 0;
    endtask

    task automatic err_clear();
        err_rd_i = 1; cyc(); clear_strobes();
        err_wr_i = 1; err_wr_data_i = 0; cyc(); clear_strobes();
    endtask

    task automatic err_set();
        err_sample_i = 1; err_level_i = 0; cyc(); clear_strobes();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        cyc(); cyc();
        check(err_flag_o, 1'b0, "R1 reset error flag");
        check(tx_end_o, 1'b1, "R1 reset end flag");
        rst_n = 1; tx_en_i = 1; cyc();

        // R2: high sample ignored, low sample sets.
        err_sample_i = 1; err_level_i = 1; cyc(); clear_strobes();
        check(err_flag_o, 1'b0, "R2 high level no set");
        err_set();
        check(err_flag_o, 1'b1, "R2 low level sets");

        // R3: unarmed write of 0 ignored, armed write clears.
        err_wr_i = 1; err_wr_data_i = 0; cyc(); clear_strobes();
        check(err_flag_o, 1'b1, "R3 unarmed write ignored");
        err_clear();
        check(err_flag_o, 1'b0, "R3 armed write clears");
        err_wr_i = 1; err_wr_data_i = 0; err_set(); // re-set and an unarmed write
        check(err_flag_o, 1'b1, "R3 disarmed after clear");

        // R4: set wins over armed clear.
        err_rd_i = 1; cyc(); clear_strobes();
        err_wr_i = 1; err_wr_data_i = 0; err_sample_i = 1; err_level_i = 0; cyc(); clear_strobes();
        check(err_flag_o, 1'b1, "R4 error set wins");

        // R5/R6: transmit enable low keeps error, no forcing while error set.
        data_wr_i = 1; cyc(); clear_strobes();
        check(tx_end_o, 1'b0, "R10 data write clears");
        tx_en_i = 0; cyc(); cyc(); cyc();
        check(err_flag_o, 1'b1, "R5 error retained with enable low");
        check(tx_end_o, 1'b0, "R6 no forcing while error set");
        err_clear();
        check(err_flag_o, 1'b0, "R3 clear with enable low");
        cyc();
        check(tx_end_o, 1'b1, "R6 idle forces end flag");

        // R11: low power with error set and end flag cleared.
        tx_en_i = 1; err_set(); data_wr_i = 1; cyc(); clear_strobes();
        check(tx_end_o, 1'b0, "R10 data write clears again");
        pwr_down_i = 1; cyc(); clear_strobes();
        check(err_flag_o, 1'b0, "R11 low power clears error");
        check(tx_end_o, 1'b1, "R11 low power sets end");

        // R10: empty-flag sequence.
        tdr_empty_i = 1;
        empty_wr_i = 1; empty_wr_data_i = 0; cyc(); clear_strobes();
        check(tx_end_o, 1'b1, "R10 unarmed empty write ignored");
        empty_rd_i = 1; cyc(); clear_strobes();
        empty_wr_i = 1; empty_wr_data_i = 0; cyc(); clear_strobes();
        check(tx_end_o, 1'b0, "R10 armed empty write clears");
        tdr_empty_i = 0; data_wr_i = 1; cyc(); clear_strobes();
        empty_rd_i = 1; cyc(); clear_strobes();
        tdr_empty_i = 1; empty_wr_i = 1; empty_wr_data_i = 0; cyc(); clear_strobes();
        check(tx_end_o, 1'b0, "R10 read while not empty does not arm");

        // R7/R8/R9 sweep: guard mode x empty x error.
        for (int gm = 0; gm < 2; gm++) begin
            for (int emp = 0; emp < 2; emp++) begin
                for (int er = 0; er < 2; er++) begin
                    int tgt;
                    tgt = (gm != 0) ? 2 : 5;
                    if (er != 0) err_set();
                    guard_mode_i = gm[0]; tdr_empty_i = emp[0];
                    data_wr_i = 1; cyc(); clear_strobes();
                    char_done_i = 1; cyc(); clear_strobes();
                    guard_mode_i = ~gm[0]; // latched at start, must not matter
                    for (int k = 1; k <= 6; k++) begin
                        cyc();
                        half_etu_tick_i = 1; cyc(); clear_strobes();
                        check(tx_end_o, (emp != 0 && er == 0 && k >= tgt),
                              (gm != 0) ? "R8 short delay tick" :
                              ((emp != 0 && er == 0) ? "R7 long delay tick" : "R9 gated delay tick"));
                    end
                    if (er != 0) err_clear();
                end
            end
        end

        // R4 for end flag: expiry and data write in the same cycle.
        guard_mode_i = 1; tdr_empty_i = 1; data_wr_i = 1; cyc(); clear_strobes();
        char_done_i = 1; cyc(); clear_strobes();
        half_etu_tick_i = 1; cyc(); clear_strobes();
        half_etu_tick_i = 1; data_wr_i = 1; cyc(); clear_strobes();
        check(tx_end_o, 1'b1, "R4 end set wins over data write");

        // R11: low power cancels a pending delay.
        data_wr_i = 1; cyc(); clear_strobes();
        char_done_i = 1; cyc(); clear_strobes();
        pwr_down_i = 1; cyc(); clear_strobes();
        data_wr_i = 1; cyc(); clear_strobes();
        for (int k = 0; k < 3; k++) begin
            half_etu_tick_i = 1; cyc(); clear_strobes();
        end
        check(tx_end_o, 1'b0, "R11 pending delay cancelled");

        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule